// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation analog-to-digital converter with eight multiplexed inputs. A start request, sampled on the system clock, captures a 3-bit channel number and a rate choice. The block then steers the external input multiplexer, opens a sampling window, and presents a trial code to an external DAC/comparator pair. The single comparator bit that returns decides each result bit in turn, most significant first.

Every conversion occupies a fixed frame of 160 conversion-clock periods, whatever the input value. The first 12 periods form the sampling window. The next eight periods settle one bit each, and the rest of the frame is padding. The conversion clock is the system clock or half of it. At the end of the frame the trial code is copied into the result register, and a one-cycle done pulse marks the update.

Top module: `sar_adc_seq`

## Requirements
- R1: With an ideal comparator (cmpIn high when the selected input is at or above trialCode), the result equals the input code, and inputs above full scale saturate at FFh.
- R2: When sampling ends, trialCode becomes 80h. In each of the next eight conversion periods one bit is decided, MSB first: the bit under trial stays set if cmpIn is high, otherwise it is cleared, and the next lower bit is set as the new trial.
- R3: done rises exactly 160 conversion-clock periods after the clock edge that accepts a start. That is 160 system cycles when halfRate is 0 and 320 when halfRate is 1.
- R4: sampleEn is high for exactly the first 12 conversion-clock periods of a conversion, and trialCode is 00h while it is high.
- R5: done is high for exactly one system cycle, in the cycle where result takes its new value, and result then equals the final trialCode.
- R6: A start request while a conversion is in progress is ignored: it changes neither the frame timing nor the result.
- R7: The channel number is captured when a start is accepted. muxSel holds it for the whole conversion, even if chanReq changes.
- R8: The rate choice (halfRate 0 = system clock, 1 = half the system clock) is captured at start, and changing it mid-conversion has no effect.
- R9: A synchronous reset returns the block to idle with result 00h, trialCode 00h, sampleEn low and done low, even mid-conversion. No done follows unless a new start is given.
- R10: result holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Conversion request, sampled each clock |
| chanReq | input | 3 | Channel to convert, captured at start |
| halfRate | input | 1 | 0: conversion clock = system clock, 1: half rate |
| cmpIn | input | 1 | Comparator result, high when input >= trial code |
| muxSel | output | 3 | Analog multiplexer select |
| sampleEn | output | 1 | Sample-and-hold enable |
| trialCode | output | 8 | Code driven to the DAC |
| result | output | 8 | Last converted byte |
| done | output | 1 | One-cycle pulse when result updates |

## Verification
The assertions assume that cmpIn is a settled function of trialCode and the latched channel by each rising edge. They also assume that startReq, chanReq and halfRate are ordinary synchronous levels. The bench keeps within this: its comparator is a combinational ideal comparison against a stored per-channel value, and it changes every input only on the falling clock edge. Inputs above 8-bit full scale are allowed so that saturation can be observed, and mid-conversion changes to chanReq, halfRate and startReq are applied at fixed points inside the frame.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic latch;    // start accepted: capture channel, clear trial code
    logic loadMsb;  // sampling over: set first trial bit
    logic decide;   // settle one bit from the comparator
    logic commit;   // frame over: copy trial code to result
  } sar_strobe_t;

endpackage

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int FRAME_CLKS  = 160,
  parameter int SAMPLE_CLKS = 12,
  localparam int CNT_W = $clog2(FRAME_CLKS),
  localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic              halfRate,
  output sar_strobe_t       strobe,
  output logic [IDX_W-1:0]  decideBit,
  output logic              sampleEn,
  output logic              done
);

  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] SAMP_LAST  = CNT_W'(SAMPLE_CLKS - 1);
  localparam logic [CNT_W-1:0] BIT_FIRST  = CNT_W'(SAMPLE_CLKS);
  localparam logic [CNT_W-1:0] BIT_END    = CNT_W'(SAMPLE_CLKS + RES_BITS);
  localparam logic [IDX_W-1:0] TOP_IDX    = IDX_W'(RES_BITS - 1);

  logic             busyQ;
  logic             rateQ;
  logic             phaseQ;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ;

  logic             accept;
  logic             tick;
  logic             lastTick;
  logic             inBits;
  logic [CNT_W-1:0] stepOffset;

  always_comb begin
    accept     = startReq && !busyQ;
    // conversion-clock enable: every cycle, or every second cycle
    tick       = busyQ && (!rateQ || phaseQ);
    lastTick   = tick && (cntQ == LAST_CNT);
    inBits     = (cntQ >= BIT_FIRST) && (cntQ < BIT_END);
    stepOffset = cntQ - BIT_FIRST;
    decideBit  = TOP_IDX - stepOffset[IDX_W-1:0];

    strobe.latch   = accept;
    strobe.loadMsb = tick && (cntQ == SAMP_LAST);
    strobe.decide  = tick && inBits;
    strobe.commit  = lastTick;

    sampleEn = busyQ && (cntQ < BIT_FIRST);
    done     = doneQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ  <= 1'b0;
      rateQ  <= 1'b0;
      phaseQ <= 1'b0;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastTick;
      if (accept) begin
        busyQ  <= 1'b1;
        rateQ  <= halfRate;
        phaseQ <= 1'b0;
        cntQ   <= '0;
      end else if (busyQ) begin
        phaseQ <= ~phaseQ;
        if (lastTick) begin
          busyQ <= 1'b0;
          cntQ  <= '0;
        end else if (tick) begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sar_adc_datapath.sv
module sar_adc_datapath
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int CH_BITS  = 3,
  localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  sar_strobe_t         strobe,
  input  logic [IDX_W-1:0]    decideBit,
  input  logic [CH_BITS-1:0]  chanReq,
  input  logic                cmpIn,
  output logic [CH_BITS-1:0]  muxSel,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] result
);

  logic [CH_BITS-1:0]  chanQ;
  logic [RES_BITS-1:0] trialQ;
  logic [RES_BITS-1:0] resultQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      chanQ   <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.latch)  chanQ   <= chanReq;
      if (strobe.commit) resultQ <= trialQ;
    end
  end

  // One register slice per result bit; each slice knows its own role.
  for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(b);
    logic setFromAbove;

    if (b < RES_BITS - 1) begin : g_lower
      localparam logic [IDX_W-1:0] UP_IDX = IDX_W'(b + 1);
      assign setFromAbove = strobe.decide && (decideBit == UP_IDX);
    end else begin : g_top
      assign setFromAbove = strobe.loadMsb;
    end

    always_ff @(posedge clk) begin
      if (rst || strobe.latch) begin
        trialQ[b] <= 1'b0;
      end else if (strobe.decide && (decideBit == MY_IDX)) begin
        trialQ[b] <= cmpIn;
      end else if (setFromAbove) begin
        trialQ[b] <= 1'b1;
      end
    end
  end

  assign muxSel    = chanQ;
  assign trialCode = trialQ;
  assign result    = resultQ;

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int CH_BITS     = 3,
  parameter int FRAME_CLKS  = 160,
  parameter int SAMPLE_CLKS = 12,
  localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic [CH_BITS-1:0]  chanReq,
  input  logic                halfRate,
  input  logic                cmpIn,
  output logic [CH_BITS-1:0]  muxSel,
  output logic                sampleEn,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] result,
  output logic                done
);

  sar_strobe_t      strobe;
  logic [IDX_W-1:0] decideBit;

  sar_adc_ctrl #(
    .RES_BITS   (RES_BITS),
    .FRAME_CLKS (FRAME_CLKS),
    .SAMPLE_CLKS(SAMPLE_CLKS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .halfRate (halfRate),
    .strobe   (strobe),
    .decideBit(decideBit),
    .sampleEn (sampleEn),
    .done     (done)
  );

  sar_adc_datapath #(
    .RES_BITS(RES_BITS),
    .CH_BITS (CH_BITS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .decideBit(decideBit),
    .chanReq  (chanReq),
    .cmpIn    (cmpIn),
    .muxSel   (muxSel),
    .trialCode(trialCode),
    .result   (result)
  );

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES_BITS = 8,
  parameter int CH_BITS  = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [CH_BITS-1:0]  muxSel,
  input logic                sampleEn,
  input logic [RES_BITS-1:0] trialCode,
  input logic [RES_BITS-1:0] result,
  input logic                done
);

  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  // R5
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_result_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (result == trialCode));

  // R4
  sample_trial_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sampleEn |-> (trialCode == '0));

  // R2
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(sampleEn)) |-> (trialCode == MSB_ONLY));

  // R7
  mux_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sampleEn && $past(sampleEn)) |-> $stable(muxSel));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !sampleEn && !done && trialCode == '0));

endmodule

bind sar_adc_seq sar_adc_seq_chk #(
  .RES_BITS(RES_BITS),
  .CH_BITS (CH_BITS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .muxSel   (muxSel),
  .sampleEn (sampleEn),
  .trialCode(trialCode),
  .result   (result),
  .done     (done)
);

// File: tb/sar_adc_seq_test.sv
`timescale 1ns/1ps
module sar_adc_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startReq = 1'b0;
  logic [2:0] chanReq = 3'd0;
  logic       halfRate = 1'b0;
  logic       cmpIn;
  logic [2:0] muxSel;
  logic       sampleEn;
  logic [7:0] trialCode;
  logic [7:0] result;
  logic       done;

  logic [8:0] vinArr [8];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // ideal comparator against the stored input of the selected channel
  always_comb cmpIn = (vinArr[muxSel] >= {1'b0, trialCode});

  sar_adc_seq uut (
    .clk(clk), .rst(rst), .startReq(startReq), .chanReq(chanReq),
    .halfRate(halfRate), .cmpIn(cmpIn), .muxSel(muxSel), .sampleEn(sampleEn),
    .trialCode(trialCode), .result(result), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {channel[12:10], halfRate[9], input value[8:0]}
  localparam logic [12:0] VEC [8] = '{
    {3'd0, 1'b0, 9'd0},
    {3'd7, 1'b0, 9'd255},
    {3'd3, 1'b1, 9'd128},
    {3'd5, 1'b0, 9'd300},
    {3'd1, 1'b1, 9'd127},
    {3'd2, 1'b0, 9'd85},
    {3'd6, 1'b0, 9'd170},
    {3'd4, 1'b1, 9'd1}
  };

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) vinArr[i] = 9'(i * 37 + 11);
    repeat (4) @(negedge clk);
    check(result == 8'h00 && !sampleEn && !done && trialCode == 8'h00,
          "R9 reset state", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [2:0] ch;
      logic       rate;
      logic [8:0] vin;
      int         r, n, doneN, sampCnt, muxBad;
      logic [7:0] expRes, expStep;
      ch   = VEC[v][12:10];
      rate = VEC[v][9];
      vin  = VEC[v][8:0];
      r    = rate ? 2 : 1;
      vinArr[ch] = vin;
      expRes  = (vin > 9'd255) ? 8'hFF : vin[7:0];
      expStep = {vin >= 9'd128, 1'b1, 6'b0};
      chanReq  = ch;
      halfRate = rate;
      startReq = 1'b1;
      n = 0; doneN = 0; sampCnt = 0; muxBad = 0;
      while (doneN == 0 && n < 700) begin
        @(negedge clk);
        n++;
        startReq = (n == 50);       // retrigger while busy: must be ignored
        if (n == 30) begin
          chanReq  = ~ch;
          halfRate = ~rate;
        end
        if (sampleEn) sampCnt++;
        if (muxSel != ch) muxBad++;
        if (n == 12 * r + 1)
          check(trialCode == 8'h80, "R2 first trial", int'(trialCode), 128);
        if (n == 13 * r + 1)
          check(trialCode == expStep, "R2 after MSB decision", int'(trialCode), int'(expStep));
        if (done) doneN = n;
      end
      startReq = 1'b0;
      check(result == expRes, "R1 converted value", int'(result), int'(expRes));
      check(doneN == 160 * r + 1, "R3 R6 R8 frame length", doneN, 160 * r + 1);
      check(sampCnt == 12 * r, "R4 sampling window", sampCnt, 12 * r);
      check(muxBad == 0, "R7 channel held", muxBad, 0);
      @(negedge clk);
      check(!done, "R5 done single cycle", int'(done), 0);
      repeat (5) @(negedge clk);
      check(result == expRes, "R10 result holds", int'(result), int'(expRes));
    end

    // no stray done from the ignored retrigger
    begin
      int extra = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R6 no extra conversion", extra, 0);
    end

    // reset in the middle of a conversion
    vinArr[2] = 9'd200;
    chanReq = 3'd2; halfRate = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(result == 8'h00 && !sampleEn && trialCode == 8'h00 && !done,
          "R9 mid-conversion reset", int'(result), 0);
    rst = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (done || sampleEn) seen++;
      end
      check(seen == 0, "R9 idle after reset", seen, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule